// File: doc/BRIEF.md
# Dual-Rate Peripheral Clock-Enable Generator

This block takes one oscillator clock and produces eight single-cycle enable strobes. One strobe paces the CPU machine cycle. The other seven pace the CAN controller, the watchdog, the counter array, the serial port and timers 0, 1 and 2. Each strobe fires once every 6 or once every 12 oscillator periods. An 8-bit rate register, loaded through a one-cycle write port and always visible on a readback output, selects the rate of each strobe.

Bit 0 of the register is a global double-speed switch. While it is clear, every strobe runs at the slow rate and the seven upper bits have no effect. While it is set, the CPU strobe runs fast. Each peripheral then runs fast when its own bit is clear and falls back to slow when its bit is set. A rate change is applied only at a period boundary, so a strobe interval is never cut short or stretched.

Top module: `clk_rate_strobe_gen`

## Requirements
- R1: On a clock edge with rst_n low, the rate register clears to 0x00, every divider restarts, and no strobe output is high in the cycles that follow while rst_n stays low.
- R2: A clock edge with wr_en high loads wr_data into the rate register, and rate_q shows it from the next cycle. With wr_en low, rate_q keeps its value.
- R3: Bit 0 is the global double-speed bit. Bit k+1 (k = 0..6) controls per_stb[k], with per_stb[0] = timer 0, [1] = timer 1, [2] = timer 2, [3] = serial port, [4] = counter array, [5] = watchdog, [6] = CAN.
- R4: With bit 0 clear, cpu_stb and every per_stb pulse once every 12 clock cycles.
- R5: With bit 0 set, cpu_stb pulses once every 6 clock cycles.
- R6: With bit 0 set, per_stb[k] pulses every 6 cycles when bit k+1 is 0 and every 12 cycles when it is 1.
- R7: With bit 0 clear, bits 7..1 have no effect on any strobe rate, for all 128 of their values.
- R8: Every strobe is high for exactly one clock cycle per pulse.
- R9: A rate change takes effect at the next period boundary of each strobe. Every interval between two pulses of one output is exactly 6 or exactly 12 cycles, including across register writes.
- R10: rate_q returns exactly the last written value, including peripheral bits that currently have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Loads wr_data into the rate register |
| wr_data | input | 8 | Value written to the rate register |
| rate_q | output | 8 | Readback of the rate register |
| cpu_stb | output | 1 | Machine-cycle enable strobe |
| per_stb | output | 7 | Peripheral enable strobes, in the order given in R3 |

## Verification
The hard case is a write that arrives in the middle of a running period. Here the old rate must finish its interval before the new rate applies, and the seven peripheral bits must do nothing while double speed is off. The stimulus walks all 256 register values in order. Each write therefore lands at an arbitrary phase of every divider, and consecutive values flip rates in both directions. After a settling window, the scoreboard measures one full interval per output and compares it with the period expected for that value. Meanwhile the checker confirms that every interval, including those that straddle a write, is exactly 6 or 12 cycles.

// File: rtl/rate_strobe_pkg.sv
// Package: shared constants and helpers for the dual-rate strobe generator.
// Assumes the slow period is a multiple of the fast one and both fit CNT_W.
package rate_strobe_pkg;
    localparam int unsigned FAST_DIV = 6;
    localparam int unsigned SLOW_DIV = 12;
    localparam int unsigned NUM_PER  = 7;
    localparam int unsigned REG_W    = NUM_PER + 1;
    localparam int unsigned CNT_W    = $clog2(SLOW_DIV);

    typedef logic [REG_W-1:0] rate_reg_t;
    typedef logic [CNT_W-1:0] div_cnt_t;

    // Returns the last count value of a period for the given rate choice.
    function automatic div_cnt_t last_count(input logic slow);
        return slow ? div_cnt_t'(SLOW_DIV - 1) : div_cnt_t'(FAST_DIV - 1);
    endfunction
endpackage

// File: rtl/rate_ctrl_reg.sv
// Module: rate_ctrl_reg
// Holds the rate register. Loads on a write strobe, clears on a synchronous
// active-low reset. Assumes the bus decode outside has already qualified wr_en.
module rate_ctrl_reg
    import rate_strobe_pkg::*;
#(
    parameter int unsigned WIDTH = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] reg_q
);
    // Register storage: clear on reset, load on write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= wr_data;
        end
    end
endmodule

// File: rtl/rate_select.sv
// Module: rate_select
// Decodes the rate register into one slow/fast request per strobe.
// Bit 0 is the global double-speed bit. A peripheral bit counts only while it
// is set, and a set peripheral bit selects the slow rate.
module rate_select
    import rate_strobe_pkg::*;
#(
    parameter int unsigned NPER = NUM_PER
) (
    input  logic [NPER:0]   reg_q,
    output logic            cpu_slow,
    output logic [NPER-1:0] per_slow
);
    logic x2_on;

    // Global speed decode.
    always_comb begin
        x2_on    = reg_q[0];
        cpu_slow = !x2_on;
    end

    // Per-peripheral decode: slow unless double speed is on and the bit is clear.
    for (genvar k = 0; k < NPER; k++) begin : g_per
        always_comb per_slow[k] = !x2_on || reg_q[k+1];
    end
endmodule

// File: rtl/strobe_divider.sv
// Module: strobe_divider
// Free-running divider that emits a registered one-cycle strobe once per
// period. The requested rate is latched only at the period boundary, so an
// interval always has the full length of one rate.
module strobe_divider
    import rate_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slow_req,
    output logic stb
);
    div_cnt_t cnt;
    logic     slow_act;
    logic     at_end;

    // End-of-period detect for the rate in force.
    always_comb at_end = (cnt == last_count(slow_act));

    // Count, wrap, latch the new rate at the wrap and emit the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            slow_act <= 1'b1;
            stb      <= 1'b0;
        end else if (at_end) begin
            cnt      <= '0;
            slow_act <= slow_req;
            stb      <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            stb      <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_rate_strobe_gen.sv
// Module: clk_rate_strobe_gen (top)
// Generates the CPU strobe and seven peripheral strobes from one clock, each at
// 1/6 or 1/12 of the clock rate as the rate register selects. Each output has
// its own divider so that rate switches never disturb another output's phase.
module clk_rate_strobe_gen
    import rate_strobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rate_q,
    output logic               cpu_stb,
    output logic [NUM_PER-1:0] per_stb
);
    logic               cpu_slow;
    logic [NUM_PER-1:0] per_slow;

    // Control register.
    rate_ctrl_reg #(.WIDTH(REG_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .reg_q   (rate_q)
    );

    // Rate decode.
    rate_select #(.NPER(NUM_PER)) u_sel (
        .reg_q    (rate_q),
        .cpu_slow (cpu_slow),
        .per_slow (per_slow)
    );

    // CPU divider.
    strobe_divider u_cpu_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_req (cpu_slow),
        .stb      (cpu_stb)
    );

    // One divider per peripheral.
    for (genvar k = 0; k < NUM_PER; k++) begin : g_per_div
        strobe_divider u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .slow_req (per_slow[k]),
            .stb      (per_stb[k])
        );
    end
endmodule

// File: rtl/clk_rate_strobe_chk.sv
// Module: clk_rate_strobe_chk
// Checker bound to the top. It watches reset behaviour, write readback, pulse
// width and pulse spacing. The spacing is tracked with counters.
module clk_rate_strobe_chk
    import rate_strobe_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic [REG_W-1:0]   rate_q,
    input logic               cpu_stb,
    input logic [NUM_PER-1:0] per_stb
);
    localparam int unsigned NOUT = NUM_PER + 1;
    logic [NOUT-1:0] all_stb;
    logic            rst_seen;
    logic            rst_prev;
    logic [4:0]      gap  [NOUT];
    logic [NOUT-1:0] seen;

    always_comb all_stb = {per_stb, cpu_stb};

    // Track whether a reset edge has occurred and the reset level one edge ago.
    always_ff @(posedge clk) begin
        rst_seen <= rst_seen || !rst_n;
        rst_prev <= rst_n;
    end

    // Gap counters: cycles since the last pulse of each output.
    for (genvar i = 0; i < NOUT; i++) begin : g_gap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap[i]  <= '0;
                seen[i] <= 1'b0;
            end else if (all_stb[i]) begin
                gap[i]  <= 5'd1;
                seen[i] <= 1'b1;
            end else if (gap[i] != 5'd31) begin
                gap[i]  <= gap[i] + 5'd1;
            end
        end

        // R9
        strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (all_stb[i] && seen[i]) |-> (gap[i] == 5'(FAST_DIV) || gap[i] == 5'(SLOW_DIV)));

        // R8
        strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
            all_stb[i] |=> !all_stb[i]);
    end

    // Reset-state checks, valid once a reset edge lies in the past.
    always @(posedge clk) begin
        if (rst_seen && !rst_prev) begin
            // R1
            reset_clear_chk: assert (rate_q == '0);
            // R1
            reset_quiet_chk: assert (all_stb == '0);
        end
    end

    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rate_q == $past(wr_data)));

    // R10
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rst_prev) |=> $stable(rate_q));
endmodule

bind clk_rate_strobe_gen clk_rate_strobe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rate_q  (rate_q),
    .cpu_stb (cpu_stb),
    .per_stb (per_stb)
);

// File: tb/clk_rate_strobe_gen_bench.sv
// Bench: scoreboard over all 256 register values. The driver writes a value,
// lets the dividers settle and pushes the expected period of each output. The
// monitor measures intervals at the falling edge and pops and compares them.
module clk_rate_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rate_q;
    logic       cpu_stb;
    logic [6:0] per_stb;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    int gap_b[8];
    int meas[8];
    logic [7:0] valid_m = '0;
    logic [7:0] seen_b = '0;
    logic [7:0] stb_all;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk_rate_strobe_gen u_clk_rate_strobe_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rate_q(rate_q), .cpu_stb(cpu_stb), .per_stb(per_stb)
    );

    assign stb_all = {per_stb, cpu_stb};

    // Monitor: measure the interval between pulses of each output.
    always @(negedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (!rst_n) begin
                gap_b[i] = 0; seen_b[i] = 1'b0;
            end else if (stb_all[i]) begin
                if (seen_b[i]) begin meas[i] = gap_b[i]; valid_m[i] = 1'b1; end
                gap_b[i] = 1; seen_b[i] = 1'b1;
            end else begin
                gap_b[i] = gap_b[i] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: write a value and push expected periods (index 0 = CPU).
    task automatic drive(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = ~v;
        check(rate_q == v, "R2/R10 readback", rate_q, v);
        repeat (30) @(negedge clk);
        valid_m = '0;
        exp_q.push_back(v[0] ? 6 : 12);
        for (int k = 0; k < 7; k++)
            exp_q.push_back((v[0] && !v[k+1]) ? 6 : 12);
        repeat (26) @(negedge clk);
        check(rate_q == v, "R2 hold", rate_q, v);
        // Pop side of the scoreboard.
        for (int i = 0; i < 8; i++) begin
            int e;
            e = exp_q.pop_front();
            if (!valid_m[i]) check(1'b0, "R9 no interval seen", i, e);
            else if (i == 0) check(meas[i] == e, v[0] ? "R5 cpu" : "R4 cpu", meas[i], e);
            else check(meas[i] == e, v[0] ? "R6 per" : "R7 per", meas[i], e);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: hold reset, check quiet outputs and cleared register.
        repeat (3) @(negedge clk);
        for (int c = 0; c < 10; c++) begin
            check(stb_all == 8'h00, "R1 strobe in reset", stb_all, 0);
            @(negedge clk);
        end
        check(rate_q == 8'h00, "R1 reset value", rate_q, 0);
        rst_n = 1'b1;
        // R3 layout is exercised through all values below.
        for (int v = 0; v < 256; v++) drive(8'(v));
        // R1: reset mid-run clears a nonzero register.
        drive(8'h5B);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(rate_q == 8'h00, "R1 reset clears", rate_q, 0);
        check(stb_all == 8'h00, "R1 quiet", stb_all, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule